// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt events on fifteen numbered lines (1 to 15) and routes them to up to four processors. Each event is latched into a shared pending register. Software can also raise lines through a force register and drop pending lines through a clear register. Each processor has its own enable mask. For every processor the block drives the number of the highest pending, enabled line, which is also its priority. A processor's trap type for a line n is 0x10+n, so the valid interrupt traps are 0x11 to 0x1F.

When a processor has taken a level, it pulses an acknowledge with that level. The block then drops the matching forced bit if the line was forced, or else the matching pending bit. Sixteen extended sources (IDs 16 to 31) can be folded onto one ordinary line, chosen when the block is built. Acknowledging that line stores the highest pending extended ID in that processor's ID register and retires that source.

All registers are 32 bits wide and sit on a simple word-addressed register port. Writes take effect at the next clock edge and reads are combinational. No port carries a data stream, so there is no valid/ready handshake and there is no back-pressure. Every pin is a plain control or status signal.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset the pending, force, mask, extended-pending and ID registers read 0, and every processor level is 0.
- R2: A line n (1..15) that is high at a clock edge sets pending bit n. The pending register is at offset 0x00, and bit n stands for line n.
- R3: In a write to the clear register (offset 0x08), bits 15:1 that are one clear the matching pending bits, and bits 31:16 that are one clear the matching extended-pending bits. Bits that are zero leave their state unchanged.
- R4: In a write to the force register (offset 0x04), bits 15:1 that are one set the matching force bits. The force bits read back at 0x04, and bits that are zero have no effect.
- R5: Processor c has a mask register at offset 0x40+4c. Mask bit n set enables line n for that processor only.
- R6: The level of processor c is the highest n for which (pending, force or extended fold) AND mask bit n is set, and 0 when there is none. The level is visible in the cycle after the state that causes it is written.
- R7: When processor c acknowledges a level L other than 0, force bit L clears if it is set; otherwise pending bit L clears. A level of 0 is ignored.
- R8: The status register (offset 0x0C) holds the processor count minus one in bits 31:28. Bit 27, the broadcast flag, reads 0, and all other bits read 0.
- R9: A pending bit that is set in the same cycle as a clear or an acknowledge of that bit stays set, because setting wins over clearing.
- R10: Extended sources 16..31 latch into the extended-pending register (offset 0x10, bit n for source n). While any of them is pending, the configured fold line (default 10) counts as pending.
- R11: When processor c acknowledges the fold line, its ID register (offset 0x80+4c, low 5 bits) loads the highest pending extended ID, so bit 4 is set, and that source's extended-pending bit clears. With none pending, the ID register loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 31 | Event inputs [31:1]: 15:1 ordinary lines, 31:16 extended sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_lvl | input | 4*NCPU | Per-processor acknowledged level, 4 bits each |
| cpu_lvl | output | 4*NCPU | Per-processor highest pending enabled level, 4 bits each |

## Verification
Setting and clearing can meet in one cycle: an event input goes high on a line while a clear-register write targets the same bit. The bench drives both strobes before the same edge and then reads the pending register, which must still show the bit. It then clears the bit again on its own to show that the clear path works. Acknowledge is also made to compete with forcing: a line that is forced and pending at once is acknowledged, and only the forced copy must go.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] OFS_PEND  = 8'h00;
  localparam logic [AW-1:0] OFS_FORCE = 8'h04;
  localparam logic [AW-1:0] OFS_CLEAR = 8'h08;
  localparam logic [AW-1:0] OFS_STAT  = 8'h0C;
  localparam logic [AW-1:0] OFS_EXTP  = 8'h10;
  localparam logic [AW-1:0] OFS_MASK  = 8'h40;
  localparam logic [AW-1:0] OFS_ID    = 8'h80;

  // highest set bit among 15..1, 0 when none
  function automatic logic [3:0] top_line(input logic [15:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  // highest extended source (bit i means ID 16+i), bit 4 set when found
  function automatic logic [4:0] top_ext(input logic [15:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) if (v[i]) r = {1'b1, 4'(i)};
    return r;
  endfunction
endpackage

// File: rtl/mpirq_prio_enc.sv
module mpirq_prio_enc (
  input  logic [15:0] req,
  input  logic [15:0] mask,
  output logic [3:0]  lvl
);
  assign lvl = mpirq_pkg::top_line(req & mask);
endmodule

// File: rtl/mpirq_ext_unit.sv
module mpirq_ext_unit #(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       ext_in,
  input  logic [15:0]       ext_clr,
  input  logic [NCPU-1:0]   ack_hit,
  output logic [15:0]       ext_pend,
  output logic              ext_any,
  output logic [NCPU*5-1:0] ext_id
);
  generate
    if (EXT_LINE != 0) begin : g_on
      logic [15:0]           pend_q;
      logic [NCPU-1:0][4:0]  id_q;
      logic [4:0]            top;
      logic [15:0]           take;

      always_comb begin
        top  = mpirq_pkg::top_ext(pend_q);
        take = ((|ack_hit) && top[4]) ? (16'(1) << top[3:0]) : '0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= '0;
          id_q   <= '0;
        end else begin
          pend_q <= (pend_q & ~ext_clr & ~take) | ext_in;
          for (int c = 0; c < NCPU; c++)
            if (ack_hit[c]) id_q[c] <= top;
        end
      end

      assign ext_pend = pend_q;
      assign ext_any  = |pend_q;
      assign ext_id   = id_q;
    end else begin : g_off
      logic unused_ext;
      assign unused_ext = ^{ext_in, ext_clr, ack_hit, clk, rst_n};
      assign ext_pend   = '0;
      assign ext_any    = 1'b0;
      assign ext_id     = '0;
    end
  endgenerate
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl #(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:1]         irq_line,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [7:0]          rd_addr,
  output logic [31:0]         rd_data,
  input  logic [NCPU-1:0]     ack_vld,
  input  logic [NCPU*4-1:0]   ack_lvl,
  output logic [NCPU*4-1:0]   cpu_lvl
);
  import mpirq_pkg::*;

  localparam logic [15:0] FOLD_BIT = (EXT_LINE != 0) ? (16'(1) << EXT_LINE) : 16'(0);

  logic [15:0]            pend_q, force_q;
  logic [NCPU-1:0][15:0]  mask_q;
  logic [15:0]            ext_pend;
  logic                   ext_any;
  logic [NCPU*5-1:0]      ext_id;
  logic [15:0]            ack_p, ack_f, eff;
  logic [NCPU-1:0]        ext_hit;
  logic                   wr_force, wr_clear;
  logic [15:0]            wdat_lo, irq_lo;
  logic                   unused_bits;

  assign unused_bits = wr_data[0];
  assign wr_force = wr_en && (wr_addr == OFS_FORCE);
  assign wr_clear = wr_en && (wr_addr == OFS_CLEAR);
  assign wdat_lo  = {wr_data[15:1], 1'b0};
  assign irq_lo   = {irq_line[15:1], 1'b0};

  // acknowledge decode: forced copy is retired first
  always_comb begin
    logic [3:0] lv;
    ack_p   = '0;
    ack_f   = '0;
    ext_hit = '0;
    for (int c = 0; c < NCPU; c++) begin
      lv = ack_lvl[c*4 +: 4];
      if (ack_vld[c] && lv != 4'd0) begin
        if (force_q[lv]) ack_f[lv] = 1'b1;
        else             ack_p[lv] = 1'b1;
        if (EXT_LINE != 0 && lv == 4'(EXT_LINE)) ext_hit[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      force_q <= '0;
      mask_q  <= '0;
    end else begin
      pend_q  <= (pend_q & ~(wr_clear ? wdat_lo : 16'(0)) & ~ack_p) | irq_lo;
      force_q <= (force_q & ~ack_f) | (wr_force ? wdat_lo : 16'(0));
      for (int c = 0; c < NCPU; c++)
        if (wr_en && wr_addr == OFS_MASK + 8'(4*c)) mask_q[c] <= wdat_lo;
    end
  end

  mpirq_ext_unit #(.NCPU(NCPU), .EXT_LINE(EXT_LINE)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (irq_line[31:16]),
    .ext_clr  (wr_clear ? wr_data[31:16] : 16'(0)),
    .ack_hit  (ext_hit),
    .ext_pend (ext_pend),
    .ext_any  (ext_any),
    .ext_id   (ext_id)
  );

  assign eff = pend_q | force_q | (ext_any ? FOLD_BIT : 16'(0));

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      mpirq_prio_enc u_enc (
        .req  (eff),
        .mask (mask_q[c]),
        .lvl  (cpu_lvl[c*4 +: 4])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_PEND:  rd_data = {16'b0, pend_q};
      OFS_FORCE: rd_data = {16'b0, force_q};
      OFS_STAT:  rd_data = {4'(NCPU-1), 1'b0, 27'b0};
      OFS_EXTP:  rd_data = {ext_pend, 16'b0};
      default:   rd_data = '0;
    endcase
    for (int c = 0; c < NCPU; c++) begin
      if (rd_addr == OFS_MASK + 8'(4*c)) rd_data = {16'b0, mask_q[c]};
      if (rd_addr == OFS_ID + 8'(4*c))   rd_data = {27'b0, ext_id[c*5 +: 5]};
    end
  end
endmodule

// File: rtl/mpirq_chk.sv
module mpirq_chk #(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [31:1]         irq_line,
  input logic                wr_en,
  input logic [7:0]          wr_addr,
  input logic [31:0]         wr_data,
  input logic [7:0]          rd_addr,
  input logic [31:0]         rd_data,
  input logic [NCPU-1:0]     ack_vld,
  input logic [NCPU*4-1:0]   ack_lvl,
  input logic [NCPU*4-1:0]   cpu_lvl,
  input logic [15:0]         pend_q,
  input logic [15:0]         force_q,
  input logic [NCPU-1:0][15:0] mask_q,
  input logic                ext_any,
  input logic [NCPU*5-1:0]   ext_id
);
  import mpirq_pkg::*;

  logic [15:0] wlo, ilo, fw, eff;
  logic        unused_chk;
  assign unused_chk = ^{irq_line[31:16], ext_id, wr_data[31:16], wr_data[0]};
  assign wlo = {wr_data[15:1], 1'b0};
  assign ilo = {irq_line[15:1], 1'b0};
  assign fw  = (wr_en && wr_addr == OFS_FORCE) ? wlo : 16'(0);
  assign eff = pend_q | force_q | ((EXT_LINE != 0 && ext_any) ? (16'(1) << EXT_LINE) : 16'(0));

  // R3: cleared bits are gone next cycle unless an event re-set them
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_CLEAR) |=> ((pend_q & $past(wlo & ~ilo)) == 16'(0)));

  // R4: forced bits are present next cycle
  p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_FORCE) |=> ((force_q & $past(wlo)) == $past(wlo)));

  // R9: an event always lands, whatever clears compete
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ilo != 16'(0)) |=> ((pend_q & $past(ilo)) == $past(ilo)));

  // R8: status layout
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == OFS_STAT) |-> (rd_data == {4'(NCPU-1), 28'b0}));

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_c
      logic [15:0] q;
      logic [3:0]  lv, al;
      assign q  = eff & mask_q[c];
      assign lv = cpu_lvl[c*4 +: 4];
      assign al = ack_lvl[c*4 +: 4];

      // R6: reported level is qualified and nothing above it is
      p_level_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lv != 4'd0) |-> ((q >> lv) == 16'(1)));
      p_level_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lv == 4'd0) |-> (q == 16'(0)));

      // R7: acknowledge of a forced level retires the force bit
      p_ack_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld[c] && al != 4'd0 && force_q[al] && !fw[al]) |=> !force_q[$past(al)]);

      // R11: acknowledge of the fold line with extended work yields a valid ID
      p_ext_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (EXT_LINE != 0 && ack_vld[c] && al == 4'(EXT_LINE) && ext_any) |=> ext_id[c*5+4]);
    end
  endgenerate
endmodule

bind mpirq_ctrl mpirq_chk #(.NCPU(NCPU), .EXT_LINE(EXT_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .ack_vld(ack_vld), .ack_lvl(ack_lvl), .cpu_lvl(cpu_lvl), .pend_q(pend_q),
  .force_q(force_q), .mask_q(mask_q), .ext_any(ext_any), .ext_id(ext_id)
);

// File: tb/mpirq_ctrl_bench.sv
module mpirq_ctrl_bench;
  localparam int NCPU = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:1]       irq_line = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [7:0]        rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NCPU-1:0]   ack_vld = '0;
  logic [NCPU*4-1:0] ack_lvl = '0;
  logic [NCPU*4-1:0] cpu_lvl;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // scoreboard: sel -1 = register read, else processor index
  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  mpirq_ctrl #(.NCPU(NCPU), .EXT_LINE(10)) u_mpirq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_vld(ack_vld), .ack_lvl(ack_lvl), .cpu_lvl(cpu_lvl)
  );

  // monitor
  always @(negedge clk) begin
    if (q_sel.size() > 0) begin
      int s; logic [31:0] e, a; string t;
      s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      a = (s < 0) ? rd_data : {28'b0, cpu_lvl[s*4 +: 4]};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick; wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    irq_line = v[31:1]; tick; irq_line = '0;
  endtask

  task automatic ack(input int c, input logic [3:0] l);
    ack_vld[c] = 1'b1; ack_lvl[c*4 +: 4] = l; tick; ack_vld = '0; ack_lvl = '0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_addr = a; q_sel.push_back(-1); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic exp_lv(input int c, input logic [3:0] e, input string t);
    q_sel.push_back(c); q_exp.push_back({28'b0, e}); q_tag.push_back(t);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1'b1; tick;
    // R1 / R8
    exp_rd(8'h00, 32'h0, "R1 pending after reset");
    exp_rd(8'h40, 32'h0, "R1 mask0 after reset");
    exp_lv(0, 4'd0, "R1 cpu0 level after reset");
    exp_lv(1, 4'd0, "R1 cpu1 level after reset");
    exp_rd(8'h0C, 32'h1000_0000, "R8 status");
    // R2
    pulse(32'h20);
    exp_rd(8'h00, 32'h20, "R2 line 5 latched");
    exp_lv(0, 4'd0, "R5 masked line hidden");
    // R5
    wr(8'h40, 32'hA0);
    exp_rd(8'h40, 32'hA0, "R5 mask0 readback");
    exp_lv(0, 4'd5, "R5 cpu0 sees line 5");
    exp_lv(1, 4'd0, "R5 cpu1 unaffected");
    // R6
    pulse(32'h88);
    exp_rd(8'h00, 32'hA8, "R2 lines 3,7 latched");
    exp_lv(0, 4'd7, "R6 highest wins");
    // R3
    wr(8'h08, 32'h80);
    exp_rd(8'h00, 32'h28, "R3 clear line 7");
    exp_lv(0, 4'd5, "R6 falls back to 5");
    // R4
    wr(8'h04, 32'h1000);
    exp_rd(8'h04, 32'h1000, "R4 force readback");
    wr(8'h44, 32'h1000);
    exp_lv(1, 4'd12, "R4 cpu1 sees forced 12");
    exp_lv(0, 4'd5, "R5 cpu0 still 5");
    // R7
    ack(1, 4'd12);
    exp_rd(8'h04, 32'h0, "R7 ack drops force");
    exp_rd(8'h00, 32'h28, "R7 pending untouched by forced ack");
    exp_lv(1, 4'd0, "R7 cpu1 idle");
    ack(0, 4'd5);
    exp_rd(8'h00, 32'h08, "R7 ack drops pending 5");
    ack(0, 4'd0);
    exp_rd(8'h00, 32'h08, "R7 level 0 ack ignored");
    // R7 force and pending both set: only force goes
    wr(8'h04, 32'h08);
    ack(0, 4'd3);
    exp_rd(8'h04, 32'h0, "R7 forced copy retired");
    exp_rd(8'h00, 32'h08, "R7 pending copy kept");
    // R9 set vs clear in the same cycle
    irq_line[3] = 1'b1; wr(8'h08, 32'h08); irq_line = '0;
    exp_rd(8'h00, 32'h08, "R9 event beats clear");
    wr(8'h08, 32'h08);
    exp_rd(8'h00, 32'h00, "R3 clear alone");
    // R3 zero bits
    pulse(32'h2);
    wr(8'h08, 32'h0);
    exp_rd(8'h00, 32'h02, "R3 zero clear no effect");
    wr(8'h08, 32'h2);
    // R10 / R11
    wr(8'h40, 32'h4A0);
    pulse(32'h0012_0000);
    exp_rd(8'h10, 32'h0012_0000, "R10 extended latched");
    exp_rd(8'h00, 32'h0, "R10 ordinary pending clear");
    exp_lv(0, 4'd10, "R10 fold line raised");
    exp_lv(1, 4'd0, "R10 cpu1 masked");
    ack(0, 4'd10);
    exp_rd(8'h80, 32'h14, "R11 id 20 first");
    exp_rd(8'h10, 32'h0002_0000, "R11 source 20 retired");
    exp_lv(0, 4'd10, "R11 fold still raised");
    ack(0, 4'd10);
    exp_rd(8'h80, 32'h11, "R11 id 17 next");
    exp_lv(0, 4'd0, "R11 fold idle");
    ack(0, 4'd10);
    exp_rd(8'h80, 32'h00, "R11 none pending gives 0");
    pulse(32'h8000_0000);
    exp_rd(8'h10, 32'h8000_0000, "R10 source 31 latched");
    wr(8'h08, 32'h8000_0000);
    exp_rd(8'h10, 32'h0, "R3 clear extended bit");
    tick; tick;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule